// File: doc/BRIEF.md
# Timed Port Command Sequencer

This block is a small self-running controller that walks a fixed program of port operations after reset. It drives a byte onto an output port with a one-cycle write strobe. It then pauses for a set number of milliseconds. After a second port write and a second pause, it captures the byte currently seen on the port input and issues a single memory write of that byte to a fixed address. When the program is exhausted it parks in a halt state until reset.

The program lives in a constant command table inside the block, indexed by a step counter. Each command names an operation, its data or address, and the pause that follows it. All pauses go through one shared countdown state. Before jumping there, the issuing step clears the countdown counter and records where execution resumes, so the pause works like a called subroutine. Time is measured only in clock cycles, using a cycles-per-millisecond parameter, and a testbench can shrink that parameter to a few cycles.

Top module: `port_cmd_sequencer`

## Requirements
- R1: Reset is synchronous and active low (`rst_n` = 0 at a rising edge). After such an edge, `port_we`, `mem_we`, `busy` and `done` are 0, and `port_wdata`, `mem_addr` and `mem_wdata` are all zero.
- R2: The first rising edge with `rst_n` high executes the first step. From the cycle after that edge, `port_we` is 1 and `port_wdata` is 0x00.
- R3: Every pause of M ms holds `busy` high for exactly M × CYC_PER_MS consecutive cycles. It starts in the same cycle as the strobe of the step that requested it.
- R4: The strobe for the second port write (`port_wdata` = 0x0F) appears exactly WAIT_MS × CYC_PER_MS + 1 cycles after the first port strobe.
- R5: WAIT_MS × CYC_PER_MS + 1 cycles after the second port strobe, `mem_we` is 1 for one cycle, with `mem_addr` = 0xDEAD and `mem_wdata` equal to `port_in` at the edge that raised the strobe. `port_in` has no effect on `mem_wdata` at any other edge.
- R6: `port_we` and `mem_we` are each high for exactly one cycle per issuing step. A full run gives two port strobes and one memory strobe.
- R7: `port_wdata`, `mem_addr` and `mem_wdata` change only in a cycle where their own strobe is high, and hold their value in all other cycles.
- R8: One cycle after the memory strobe, `done` goes high. It stays high until reset, with `busy`, `port_we` and `mem_we` held low.
- R9: Reset asserted in the middle of a pause abandons the program. After release, the sequence restarts from the first step with the R2 to R5 timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| port_in | input | 8 | Byte currently read back from the port |
| port_wdata | output | 8 | Byte driven to the port, held between writes |
| port_we | output | 1 | One-cycle port write strobe |
| mem_addr | output | 16 | Memory write address, held between writes |
| mem_wdata | output | 8 | Memory write data, held between writes |
| mem_we | output | 1 | One-cycle memory write strobe |
| busy | output | 1 | High while the shared pause state is counting |
| done | output | 1 | High in the terminal halt state |

## Verification
Two situations are hard to reach from the ports. One is a reset landing while the shared countdown is part-way through a pause, with the counter and the resume register both holding live values. The other is proving that the capture samples `port_in` at exactly one edge. The stimulus releases reset, runs about half of the first pause, and then pulls reset low before running a full sequence. During every run, `port_in` carries a decoy value on every edge except the capture edge, so a capture taken a cycle early or late shows up as a wrong memory byte.

// File: rtl/seq_pkg.sv
// Shared types for the timed port command sequencer.
// Assumes a command program of at most four entries; widths of the
// command fields are fixed here and reused by every module.
package seq_pkg;

    localparam int unsigned CMD_DATA_W = 8;
    localparam int unsigned CMD_ADDR_W = 16;
    localparam int unsigned CMD_MS_W   = 8;
    localparam int unsigned NUM_CMDS   = 4;
    localparam int unsigned PC_W       = $clog2(NUM_CMDS);

    // Operation carried by one command entry.
    typedef enum logic [1:0] {
        OP_PORT_WR = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_HALT    = 2'd2
    } op_e;

    // Controller state; only ever loaded with constants or the resume register.
    typedef enum logic [1:0] {
        ST_CMD   = 2'd0,
        ST_DELAY = 2'd1,
        ST_HALT  = 2'd2
    } state_e;

    // One command: operation, payload byte, memory address, pause afterwards.
    typedef struct packed {
        op_e                   op;
        logic [CMD_DATA_W-1:0] data;
        logic [CMD_ADDR_W-1:0] addr;
        logic [CMD_MS_W-1:0]   wait_ms;
    } cmd_t;

endpackage

// File: rtl/seq_cmd_rom.sv
// Constant command table for the sequencer.
// What it does: maps a step index to a command entry. The program is
// computed from parameters: write FIRST_VAL, pause, write SECOND_VAL,
// pause, capture to CAP_ADDR, halt.
// Assumes: the index never exceeds NUM_CMDS-1 (the halt entry does not advance).
module seq_cmd_rom
    import seq_pkg::*;
#(
    parameter logic [CMD_DATA_W-1:0] FIRST_VAL  = 8'h00,
    parameter logic [CMD_DATA_W-1:0] SECOND_VAL = 8'h0F,
    parameter int unsigned           WAIT_MS    = 10,
    parameter logic [CMD_ADDR_W-1:0] CAP_ADDR   = 16'hDEAD
) (
    input  logic [PC_W-1:0] pc,
    output cmd_t            cmd
);

    localparam logic [CMD_MS_W-1:0] WAIT_C = CMD_MS_W'(WAIT_MS);

    // Builds the entry for one program slot.
    function automatic cmd_t build_cmd(input int unsigned idx);
        cmd_t c;
        c = '{op: OP_HALT, data: '0, addr: '0, wait_ms: '0};
        case (idx)
            0: c = '{op: OP_PORT_WR, data: FIRST_VAL,  addr: '0,       wait_ms: WAIT_C};
            1: c = '{op: OP_PORT_WR, data: SECOND_VAL, addr: '0,       wait_ms: WAIT_C};
            2: c = '{op: OP_CAPTURE, data: '0,         addr: CAP_ADDR, wait_ms: '0};
            default: c = '{op: OP_HALT, data: '0, addr: '0, wait_ms: '0};
        endcase
        return c;
    endfunction

    cmd_t table_w [NUM_CMDS];

    // Fill every slot of the table from the builder function.
    for (genvar i = 0; i < NUM_CMDS; i++) begin : g_slot
        assign table_w[i] = build_cmd(i);
    end

    // Select the entry for the current step.
    assign cmd = table_w[pc];

endmodule

// File: rtl/seq_delay.sv
// Shared pause counter.
// What it does: counts clock cycles while 'run' is high and flags 'expire'
// in the last counted cycle (count == limit-1). 'clr' zeroes the count.
// Assumes: limit is nonzero and stable while run is high; clr and run are
// never high together.
module seq_delay #(
    parameter int unsigned CNT_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    // Last counted cycle of the pause.
    assign expire = run && (cnt_q == limit - 1'b1);

    // Cycle counter, kept apart from the controller state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run && !expire) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < limit)); // R3

    AST_CLR_RUN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr && run)); // R3

endmodule

// File: rtl/seq_ctrl.sv
// Sequencer state machine.
// What it does: executes the command at the current step. A port write or
// capture raises its strobe for one cycle. A command with a pause clears the
// counter, loads the resume register and enters the shared pause state,
// which jumps back to the resume state when the counter expires.
// Assumes: the command table ends with a halt entry.
module seq_ctrl
    import seq_pkg::*;
#(
    parameter int unsigned CYC_PER_MS = 250000,
    parameter int unsigned CNT_W      = 26
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  cmd_t                  cmd_i,
    input  logic [CMD_DATA_W-1:0] port_in,
    input  logic                  dly_expire,
    output logic [PC_W-1:0]       pc,
    output logic                  dly_clr,
    output logic                  dly_run,
    output logic [CNT_W-1:0]      dly_limit,
    output logic [CMD_DATA_W-1:0] port_wdata,
    output logic                  port_we,
    output logic [CMD_ADDR_W-1:0] mem_addr,
    output logic [CMD_DATA_W-1:0] mem_wdata,
    output logic                  mem_we,
    output logic                  busy,
    output logic                  done
);

    localparam logic [CNT_W-1:0] CPM_C = CNT_W'(CYC_PER_MS);

    state_e           state_q;
    state_e           ret_q;
    logic [PC_W-1:0]  pc_q;
    logic [CNT_W-1:0] limit_q;
    logic             issue;
    logic             wants_pause;
    logic [CNT_W-1:0] limit_d;

    // Decode whether the current step issues an operation followed by a pause.
    assign issue       = (state_q == ST_CMD) && (cmd_i.op != OP_HALT);
    assign wants_pause = issue && (cmd_i.wait_ms != '0);
    assign limit_d     = CNT_W'(cmd_i.wait_ms) * CPM_C;

    // Counter handshake: clear on entry, run while pausing.
    assign dly_clr   = wants_pause;
    assign dly_run   = (state_q == ST_DELAY);
    assign dly_limit = limit_q;

    assign pc   = pc_q;
    assign busy = (state_q == ST_DELAY);
    assign done = (state_q == ST_HALT);

    // Main sequencing: strobes default low, steps load data and targets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_CMD;
            ret_q      <= ST_CMD;
            pc_q       <= '0;
            limit_q    <= '0;
            port_wdata <= '0;
            port_we    <= 1'b0;
            mem_addr   <= '0;
            mem_wdata  <= '0;
            mem_we     <= 1'b0;
        end else begin
            port_we <= 1'b0;
            mem_we  <= 1'b0;
            case (state_q)
                ST_CMD: begin
                    case (cmd_i.op)
                        OP_PORT_WR: begin
                            port_wdata <= cmd_i.data;
                            port_we    <= 1'b1;
                            pc_q       <= pc_q + 1'b1;
                        end
                        OP_CAPTURE: begin
                            mem_addr  <= cmd_i.addr;
                            mem_wdata <= port_in;
                            mem_we    <= 1'b1;
                            pc_q      <= pc_q + 1'b1;
                        end
                        default: begin
                            state_q <= ST_HALT;
                        end
                    endcase
                    if (wants_pause) begin
                        ret_q   <= ST_CMD;
                        limit_q <= limit_d;
                        state_q <= ST_DELAY;
                    end
                end
                ST_DELAY: begin
                    if (dly_expire) begin
                        state_q <= ret_q;
                    end
                end
                default: begin
                    state_q <= ST_HALT;
                end
            endcase
        end
    end

    AST_RET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DELAY && dly_expire) |=> (state_q == $past(ret_q))); // R3

    AST_PORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        port_we |=> !port_we); // R6

    AST_MEM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we); // R6

    AST_PORT_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !port_we |-> $stable(port_wdata)); // R7

    AST_MEM_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we |-> ($stable(mem_wdata) && $stable(mem_addr))); // R7

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && !port_we && !mem_we && !busy)); // R8

endmodule

// File: rtl/port_cmd_sequencer.sv
// Top of the timed port command sequencer.
// What it does: joins the command table, the controller and the shared
// pause counter. After reset it writes FIRST_VAL to the port, pauses
// WAIT_MS ms, writes SECOND_VAL, pauses again, stores port_in to CAP_ADDR
// and halts.
// Assumes: CYC_PER_MS and WAIT_MS are nonzero; reset is synchronous, active low.
module port_cmd_sequencer
    import seq_pkg::*;
#(
    parameter int unsigned           CYC_PER_MS = 250000,
    parameter int unsigned           WAIT_MS    = 10,
    parameter logic [CMD_DATA_W-1:0] FIRST_VAL  = 8'h00,
    parameter logic [CMD_DATA_W-1:0] SECOND_VAL = 8'h0F,
    parameter logic [CMD_ADDR_W-1:0] CAP_ADDR   = 16'hDEAD
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CMD_DATA_W-1:0] port_in,
    output logic [CMD_DATA_W-1:0] port_wdata,
    output logic                  port_we,
    output logic [CMD_ADDR_W-1:0] mem_addr,
    output logic [CMD_DATA_W-1:0] mem_wdata,
    output logic                  mem_we,
    output logic                  busy,
    output logic                  done
);

    localparam int unsigned MAX_MS = (1 << CMD_MS_W) - 1;
    localparam int unsigned CNT_W  = $clog2(MAX_MS * CYC_PER_MS + 1);

    cmd_t             cmd;
    logic [PC_W-1:0]  pc;
    logic             dly_clr;
    logic             dly_run;
    logic [CNT_W-1:0] dly_limit;
    logic             dly_expire;

    seq_cmd_rom #(
        .FIRST_VAL (FIRST_VAL),
        .SECOND_VAL(SECOND_VAL),
        .WAIT_MS   (WAIT_MS),
        .CAP_ADDR  (CAP_ADDR)
    ) u_rom (
        .pc (pc),
        .cmd(cmd)
    );

    seq_ctrl #(
        .CYC_PER_MS(CYC_PER_MS),
        .CNT_W     (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_i     (cmd),
        .port_in   (port_in),
        .dly_expire(dly_expire),
        .pc        (pc),
        .dly_clr   (dly_clr),
        .dly_run   (dly_run),
        .dly_limit (dly_limit),
        .port_wdata(port_wdata),
        .port_we   (port_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .busy      (busy),
        .done      (done)
    );

    seq_delay #(
        .CNT_W(CNT_W)
    ) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (dly_clr),
        .run   (dly_run),
        .limit (dly_limit),
        .expire(dly_expire)
    );

    AST_CAPTURE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == CAP_ADDR)); // R5

    AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R8

    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_we && mem_we)); // R6

endmodule

// File: tb/test_port_cmd_sequencer.sv
`timescale 1ns/1ps
module test_port_cmd_sequencer;

    localparam int unsigned CPM   = 4;
    localparam int unsigned WMS   = 10;
    localparam int          L     = CPM * WMS;
    localparam logic [15:0] CAP_A = 16'hDEAD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  port_in = 8'h00;
    logic [7:0]  port_wdata;
    logic        port_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        busy;
    logic        done;

    int n_chk = 0;
    int n_fail = 0;

    port_cmd_sequencer #(
        .CYC_PER_MS(CPM),
        .WAIT_MS   (WMS),
        .FIRST_VAL (8'h00),
        .SECOND_VAL(8'h0F),
        .CAP_ADDR  (CAP_A)
    ) i_port_cmd_sequencer (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_in   (port_in),
        .port_wdata(port_wdata),
        .port_we   (port_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .busy      (busy),
        .done      (done)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // R1: hold reset over three edges and check every output.
    task automatic t_reset(input string req);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(port_we == 1'b0,     req, "port_we in reset",    32'(port_we), 0);
        chk(mem_we == 1'b0,      req, "mem_we in reset",     32'(mem_we), 0);
        chk(busy == 1'b0,        req, "busy in reset",       32'(busy), 0);
        chk(done == 1'b0,        req, "done in reset",       32'(done), 0);
        chk(port_wdata == 8'h00, req, "port_wdata in reset", 32'(port_wdata), 0);
        chk(mem_addr == 16'h0,   req, "mem_addr in reset",   32'(mem_addr), 0);
        chk(mem_wdata == 8'h00,  req, "mem_wdata in reset",  32'(mem_wdata), 0);
    endtask

    // Release reset and compare every output each cycle for 'upto' cycles.
    task automatic t_run(input logic [7:0] cap, input int upto, input string tag);
        int first_pw = -1;
        int second_pw = -1;
        int n_pw = 0;
        int n_mw = 0;
        port_in = ~cap;
        rst_n = 1'b1;
        for (int n = 1; n <= upto; n++) begin
            @(negedge clk);
            begin
                bit e_pw = (n == 1) || (n == L + 2);
                logic [7:0] e_pd = (n >= L + 2) ? 8'h0F : 8'h00;
                bit e_busy = ((n >= 1) && (n <= L)) || ((n >= L + 2) && (n <= 2 * L + 1));
                bit e_mw = (n == 2 * L + 3);
                logic [15:0] e_ma = (n >= 2 * L + 3) ? CAP_A : 16'h0000;
                logic [7:0] e_md = (n >= 2 * L + 3) ? cap : 8'h00;
                bit e_done = (n >= 2 * L + 4);
                chk(port_we == e_pw,    (n == 1) ? "R2" : "R6", {tag, " port_we"}, 32'(port_we), 32'(e_pw));
                chk(port_wdata == e_pd, (n == 1) ? "R2" : "R7", {tag, " port_wdata"}, 32'(port_wdata), 32'(e_pd));
                chk(busy == e_busy,     "R3", {tag, " busy"}, 32'(busy), 32'(e_busy));
                chk(mem_we == e_mw,     "R5", {tag, " mem_we"}, 32'(mem_we), 32'(e_mw));
                chk(mem_addr == e_ma,   "R5", {tag, " mem_addr"}, 32'(mem_addr), 32'(e_ma));
                chk(mem_wdata == e_md,  "R5", {tag, " mem_wdata"}, 32'(mem_wdata), 32'(e_md));
                chk(done == e_done,     "R8", {tag, " done"}, 32'(done), 32'(e_done));
            end
            if (port_we) begin
                n_pw++;
                if (first_pw < 0) first_pw = n;
                else if (second_pw < 0) second_pw = n;
            end
            if (mem_we) n_mw++;
            // Decoy on every edge except the capture edge.
            port_in = (n == 2 * L + 2) ? cap : (~cap ^ 8'(n));
            if (port_in == cap && n != 2 * L + 2) port_in = ~cap;
        end
        if (upto >= 2 * L + 4) begin
            chk(second_pw - first_pw == L + 1, "R4", {tag, " write spacing"},
                32'(second_pw - first_pw), 32'(L + 1));
            chk(n_pw == 2, "R6", {tag, " port strobe count"}, 32'(n_pw), 2);
            chk(n_mw == 1, "R6", {tag, " mem strobe count"}, 32'(n_mw), 1);
        end
    endtask

    // Scenario: reset values.
    task automatic t_reset_state();
        t_reset("R1");
    endtask

    // Scenario: full program, then a long halt (R2 R3 R4 R5 R6 R7 R8).
    task automatic t_full(input logic [7:0] cap, input string tag);
        t_reset("R1");
        t_run(cap, 2 * L + 60, tag);
    endtask

    // Scenario R9: reset in the middle of the first pause, then restart.
    task automatic t_mid_reset();
        t_reset("R1");
        t_run(8'h77, L / 2, "R9 partial");
        chk(busy == 1'b1, "R9", "busy mid pause", 32'(busy), 1);
        t_reset("R9");
        t_run(8'hC3, 2 * L + 10, "R9 restart");
    endtask

    initial begin
        t_reset_state();
        t_full(8'hA5, "run A5");
        t_full(8'h3C, "run 3C");
        t_mid_reset();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule